// File: doc/BRIEF.md
# Nonvolatile Memory Write and Erase Sequencer

This block sits between a CPU register bus and an on-chip nonvolatile array. Software picks a target (data EEPROM, program memory or configuration space) and chooses between write and erase in a control register. It loads a 24-bit address pointer and an 8-bit data latch. For program-memory row writes, it fills a byte-wide holding buffer one entry at a time by table-write accesses. A start request is honoured only after a two-byte unlock handshake. The block then drives a strobe interface to the array and models the programming time with a cycle counter. At the end it clears the start bit and raises a sticky completion flag.

A program-memory write streams every holding byte to the row selected by the upper pointer bits, then refills the buffer with 0xFF. A single-byte write sends the latch to the full pointer address. An erase sends one row-aligned strobe. A warm reset that lands during an operation stops it and leaves an error flag set.

Top module: `nvm_wr_ctrl`

## Requirements
- R1: After the power-on reset `rst`: the control register (offset 0) reads 0x00, the completion flag (offset 7, bit 0) and `irq` are 0, and every holding-buffer byte is 0xFF.
- R2: The unlock register at offset 1 holds no state and always reads 0x00, whatever was written to it.
- R3: Control register layout: bit 0 start, bit 1 write-enable, bit 2 error, bit 3 erase-enable, bit 6 configuration-select, bit 7 memory-select. A control write with bit 0 set starts an operation only when all of the following hold: the stored write-enable was already 1; the previous two bus writes were 0x55 and then 0xAA to offset 1, both made while write-enable was 1; and the control write itself keeps bit 1 set. Any other start request leaves bit 0 at 0 and sets bit 2.
- R4: Software cannot clear the start bit while an operation runs. Hardware clears it after the operation. Sampled once per cycle from the accepting write, it reads 1 for 1+PROG_CYCLES cycles for a single-strobe operation and for HOLD_DEPTH+PROG_CYCLES cycles for a row write.
- R5: `mem_target` is 2'b10 (configuration) whenever bit 6 is 1, whatever bit 7 holds. Otherwise it is 2'b01 (program) when bit 7 is 1 and 2'b00 (data) when bit 7 is 0.
- R6: With bit 3 set, the start produces exactly one strobe with `mem_erase`=1, at the pointer address with its low log2(HOLD_DEPTH) bits forced to zero.
- R7: A write to offset 6 copies the data latch (offset 2) into the holding entry indexed by the pointer's low log2(HOLD_DEPTH) bits. It is ignored while an operation runs.
- R8: A program-memory write (bit 6=0, bit 7=1, bit 3=0) issues HOLD_DEPTH strobes, one per cycle, with index i ascending. Strobe i has address {pointer upper bits, i} and data equal to holding entry i. At completion the whole buffer returns to 0xFF.
- R9: A data or configuration write (bit 3=0) issues one strobe with `mem_addr` equal to the pointer and `mem_wdata` equal to the latch.
- R10: The completion flag (offset 7 bit 0, mirrored on `irq`) is set when an operation completes. A write of 0 to that bit clears it, and a write of 1 has no effect.
- R11: A `warm_rst` pulse during an operation stops it at once: no further strobes, start bit 0, error bit 1, and no completion flag. Writing 0 to bit 2 clears the error bit.
- R12: The pointer bytes are read/write at offsets 3 (bits 7:0), 4 (bits 15:8) and 5 (bits 23:16). The latch is read/write at offset 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| warm_rst | input | 1 | Warm reset; aborts a running operation and flags an error |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` (combinational) |
| irq | output | 1 | Completion flag |
| mem_stb | output | 1 | One array access this cycle |
| mem_target | output | 2 | 00 data, 01 program, 10 configuration |
| mem_erase | output | 1 | Access is a row erase |
| mem_addr | output | 24 | Array byte address |
| mem_wdata | output | 8 | Array write data |

## Verification
The hardest situation to reach is a warm reset that lands in the middle of a row write. The stimulus gets there by arming and starting a program-memory write, waiting a fixed number of cycles into the strobe burst, and then pulsing `warm_rst`. The bench checks that the strobe count freezes below the row size, that the start bit drops, and that the error bit rises with no completion flag. The unlock handshake is probed with each way of breaking it: a missing first key, a missing second key, a stray write between the keys, the keys in reverse order, keys sent without write-enable, and a stray write between the keys and the start.

// File: rtl/nvm_wr_pkg.sv
package nvm_wr_pkg;

    localparam int BYTE_W   = 8;
    localparam int PTR_W    = 3 * BYTE_W;

    localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h55;
    localparam logic [BYTE_W-1:0] KEY_SECOND = 8'hAA;

    // control register bit positions
    localparam int CB_START = 0;
    localparam int CB_WEN   = 1;
    localparam int CB_ERR   = 2;
    localparam int CB_ERASE = 3;
    localparam int CB_CFG   = 6;
    localparam int CB_MEM   = 7;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_UNLOCK = 3'd1,
        RA_LATCH  = 3'd2,
        RA_PTR_LO = 3'd3,
        RA_PTR_HI = 3'd4,
        RA_PTR_UP = 3'd5,
        RA_TBLWR  = 3'd6,
        RA_FLAG   = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        TGT_DATA = 2'b00,
        TGT_PROG = 2'b01,
        TGT_CFG  = 2'b10
    } target_e;

    typedef enum logic [1:0] {
        UL_IDLE,
        UL_HALF,
        UL_ARMED
    } ul_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT
    } sq_state_e;

    typedef struct packed {
        logic mem_sel;
        logic cfg_sel;
        logic erase_en;
        logic err;
        logic wen;
        logic start;
    } ctrl_t;

    typedef struct packed {
        target_e           tgt;
        logic              erase;
        logic [PTR_W-1:0]  ptr;
        logic [BYTE_W-1:0] data;
    } op_t;

    function automatic target_e pick_target(input logic cfg, input logic mem);
        if (cfg)      return TGT_CFG;
        else if (mem) return TGT_PROG;
        else          return TGT_DATA;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_ctrl(input ctrl_t c);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[CB_START] = c.start;
        b[CB_WEN]   = c.wen;
        b[CB_ERR]   = c.err;
        b[CB_ERASE] = c.erase_en;
        b[CB_CFG]   = c.cfg_sel;
        b[CB_MEM]   = c.mem_sel;
        return b;
    endfunction

endpackage

// File: rtl/nvm_wr_unlock.sv
module nvm_wr_unlock
    import nvm_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wen,
    output logic              armed
);

    ul_state_e st_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st_q <= UL_IDLE;
        end else if (wr_en) begin
            if (reg_addr_e'(wr_addr) == RA_UNLOCK && wen && wr_data == KEY_FIRST)
                st_q <= UL_HALF;
            else if (reg_addr_e'(wr_addr) == RA_UNLOCK && wen && wr_data == KEY_SECOND
                     && st_q == UL_HALF)
                st_q <= UL_ARMED;
            else
                st_q <= UL_IDLE;
        end
    end

    assign armed = (st_q == UL_ARMED);

    // R3: arming only ever follows the half-unlocked state
    assert_arm_after_half_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(st_q == UL_HALF));

endmodule

// File: rtl/nvm_wr_hold_buf.sv
module nvm_wr_hold_buf
    import nvm_wr_pkg::*;
#(
    parameter int HOLD_DEPTH = 64,
    parameter int HOLD_AW    = $clog2(HOLD_DEPTH)
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               refill,
    input  logic               wr_en,
    input  logic [HOLD_AW-1:0] wr_idx,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic [HOLD_AW-1:0] rd_idx,
    output logic [BYTE_W-1:0]  rd_data
);

    logic [BYTE_W-1:0] ent_q [HOLD_DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < HOLD_DEPTH; i++) begin
            if (rst || refill)
                ent_q[i] <= '1;
            else if (wr_en && wr_idx == HOLD_AW'(i))
                ent_q[i] <= wr_data;
        end
    end

    assign rd_data = ent_q[rd_idx];

    // R7: loads never collide with the post-write refill
    assert_no_load_on_refill_R7: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && refill));

endmodule

// File: rtl/nvm_wr_seq.sv
module nvm_wr_seq
    import nvm_wr_pkg::*;
#(
    parameter int PROG_CYCLES = 16,
    parameter int HOLD_DEPTH  = 64,
    parameter int HOLD_AW     = $clog2(HOLD_DEPTH)
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               abort,
    input  logic               go,
    input  op_t                op_in,
    input  logic [BYTE_W-1:0]  hold_data,
    output logic [HOLD_AW-1:0] hold_idx,
    output logic               busy,
    output logic               done,
    output logic               refill,
    output logic               mem_stb,
    output logic [1:0]         mem_target,
    output logic               mem_erase,
    output logic [PTR_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0]  mem_wdata
);

    localparam int                 CNT_W    = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0]   CNT_LAST = CNT_W'(PROG_CYCLES - 1);
    localparam logic [HOLD_AW-1:0] IDX_LAST = HOLD_AW'(HOLD_DEPTH - 1);

    sq_state_e          st_q;
    op_t                op_q;
    logic [HOLD_AW-1:0] idx_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               row_op;
    logic [PTR_W-1:0]   row_base;

    assign row_op   = (op_q.tgt == TGT_PROG) && !op_q.erase;
    assign row_base = {op_q.ptr[PTR_W-1:HOLD_AW], {HOLD_AW{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_IDLE;
            op_q  <= '0;
            idx_q <= '0;
            cnt_q <= '0;
        end else if (abort) begin
            st_q  <= SQ_IDLE;
            idx_q <= '0;
            cnt_q <= '0;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (go) begin
                        op_q  <= op_in;
                        idx_q <= '0;
                        st_q  <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: begin
                    if (!row_op || idx_q == IDX_LAST) begin
                        st_q  <= SQ_WAIT;
                        cnt_q <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                SQ_WAIT: begin
                    if (cnt_q == CNT_LAST) st_q <= SQ_IDLE;
                    else                   cnt_q <= cnt_q + 1'b1;
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = (st_q != SQ_IDLE);
        done       = (st_q == SQ_WAIT) && (cnt_q == CNT_LAST) && !abort;
        refill     = done && row_op;
        mem_stb    = (st_q == SQ_ISSUE);
        mem_target = op_q.tgt;
        mem_erase  = op_q.erase;
        hold_idx   = idx_q;
        if (row_op) begin
            mem_addr  = row_base | PTR_W'(idx_q);
            mem_wdata = hold_data;
        end else if (op_q.erase) begin
            mem_addr  = row_base;
            mem_wdata = '1;
        end else begin
            mem_addr  = op_q.ptr;
            mem_wdata = op_q.data;
        end
    end

    // R6: erase strobes are row aligned
    assert_erase_row_aligned_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_stb && mem_erase) |-> (mem_addr[HOLD_AW-1:0] == '0));

    // R8: strobes are issued only while an operation is in flight
    assert_strobe_only_busy_R8: assert property (@(posedge clk) disable iff (rst)
        mem_stb |-> busy);

    // R8: row index advances by one per strobe during a row write
    assert_row_index_step_R8: assert property (@(posedge clk) disable iff (rst || abort)
        (mem_stb && row_op && idx_q != IDX_LAST) |=> (mem_stb && idx_q == $past(idx_q) + 1'b1));

    // R4: programming timer never runs past its limit
    assert_timer_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_WAIT) |-> (cnt_q <= CNT_LAST));

endmodule

// File: rtl/nvm_wr_ctrl.sv
module nvm_wr_ctrl
    import nvm_wr_pkg::*;
#(
    parameter int PROG_CYCLES = 16,
    parameter int HOLD_DEPTH  = 64
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        warm_rst,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq,
    output logic        mem_stb,
    output logic [1:0]  mem_target,
    output logic        mem_erase,
    output logic [23:0] mem_addr,
    output logic [7:0]  mem_wdata
);

    localparam int HOLD_AW = $clog2(HOLD_DEPTH);

    logic              start_q, wen_q, err_q, erase_q, cfg_q, mem_q, done_q;
    logic [BYTE_W-1:0] latch_q;
    logic [PTR_W-1:0]  ptr_q;

    logic wr_ctrl, wr_flag, wr_tbl, req_start, accept, reject;
    logic armed, busy, seq_done, refill;
    logic [HOLD_AW-1:0] hold_idx;
    logic [BYTE_W-1:0]  hold_data;
    op_t                op_new;
    ctrl_t              ctrl_view;
    reg_addr_e          ra;

    assign ra        = reg_addr_e'(bus_addr);
    assign wr_ctrl   = bus_wr && ra == RA_CTRL;
    assign wr_flag   = bus_wr && ra == RA_FLAG;
    assign wr_tbl    = bus_wr && ra == RA_TBLWR && !busy && !warm_rst;
    assign req_start = wr_ctrl && bus_wdata[CB_START] && !busy && !warm_rst;
    assign accept    = req_start && armed && wen_q && bus_wdata[CB_WEN];
    assign reject    = req_start && !accept;

    always_comb begin
        op_new.tgt   = pick_target(bus_wdata[CB_CFG], bus_wdata[CB_MEM]);
        op_new.erase = bus_wdata[CB_ERASE];
        op_new.ptr   = ptr_q;
        op_new.data  = latch_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            wen_q   <= 1'b0;
            err_q   <= 1'b0;
            erase_q <= 1'b0;
            cfg_q   <= 1'b0;
            mem_q   <= 1'b0;
            done_q  <= 1'b0;
            latch_q <= '0;
            ptr_q   <= '0;
        end else begin
            if (warm_rst) begin
                start_q <= 1'b0;
                wen_q   <= 1'b0;
                if (busy) err_q <= 1'b1;
            end else begin
                if (wr_ctrl) begin
                    wen_q   <= bus_wdata[CB_WEN];
                    erase_q <= bus_wdata[CB_ERASE];
                    cfg_q   <= bus_wdata[CB_CFG];
                    mem_q   <= bus_wdata[CB_MEM];
                    err_q   <= (err_q & bus_wdata[CB_ERR]) | reject;
                end
                if (accept)        start_q <= 1'b1;
                else if (seq_done) start_q <= 1'b0;
            end
            if (seq_done)                    done_q <= 1'b1;
            else if (wr_flag && !bus_wdata[0]) done_q <= 1'b0;
            if (bus_wr) begin
                case (ra)
                    RA_LATCH:  latch_q       <= bus_wdata;
                    RA_PTR_LO: ptr_q[7:0]    <= bus_wdata;
                    RA_PTR_HI: ptr_q[15:8]   <= bus_wdata;
                    RA_PTR_UP: ptr_q[23:16]  <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    nvm_wr_unlock u_unlock (
        .clk     (clk),
        .rst     (rst),
        .abort   (warm_rst),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .wen     (wen_q),
        .armed   (armed)
    );

    nvm_wr_hold_buf #(
        .HOLD_DEPTH (HOLD_DEPTH),
        .HOLD_AW    (HOLD_AW)
    ) u_hold (
        .clk     (clk),
        .rst     (rst),
        .refill  (refill),
        .wr_en   (wr_tbl),
        .wr_idx  (ptr_q[HOLD_AW-1:0]),
        .wr_data (latch_q),
        .rd_idx  (hold_idx),
        .rd_data (hold_data)
    );

    nvm_wr_seq #(
        .PROG_CYCLES (PROG_CYCLES),
        .HOLD_DEPTH  (HOLD_DEPTH),
        .HOLD_AW     (HOLD_AW)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .abort      (warm_rst),
        .go         (accept),
        .op_in      (op_new),
        .hold_data  (hold_data),
        .hold_idx   (hold_idx),
        .busy       (busy),
        .done       (seq_done),
        .refill     (refill),
        .mem_stb    (mem_stb),
        .mem_target (mem_target),
        .mem_erase  (mem_erase),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    always_comb begin
        ctrl_view.start    = start_q;
        ctrl_view.wen      = wen_q;
        ctrl_view.err      = err_q;
        ctrl_view.erase_en = erase_q;
        ctrl_view.cfg_sel  = cfg_q;
        ctrl_view.mem_sel  = mem_q;
        case (ra)
            RA_CTRL:   bus_rdata = pack_ctrl(ctrl_view);
            RA_LATCH:  bus_rdata = latch_q;
            RA_PTR_LO: bus_rdata = ptr_q[7:0];
            RA_PTR_HI: bus_rdata = ptr_q[15:8];
            RA_PTR_UP: bus_rdata = ptr_q[23:16];
            RA_FLAG:   bus_rdata = {7'b0, done_q};
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = done_q;

    // R2: unlock offset is never backed by storage
    assert_unlock_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (ra == RA_UNLOCK) |-> (bus_rdata == 8'h00));

    // R3: start only rises from an armed handshake with write-enable held
    assert_start_needs_arm_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(start_q) |-> ($past(armed) && $past(wen_q)));

    // R4: start cannot be dropped before the sequencer finishes
    assert_start_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (start_q && !seq_done && !warm_rst) |=> start_q);

    // R4: start bit and sequencer activity agree
    assert_start_tracks_seq_R4: assert property (@(posedge clk) disable iff (rst)
        start_q == busy);

    // R10: completion always leaves the flag set
    assert_done_sets_flag_R10: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> done_q);

    // R11: an aborted operation leaves the error bit set and start clear
    assert_abort_flags_err_R11: assert property (@(posedge clk) disable iff (rst)
        (warm_rst && busy) |=> (err_q && !start_q));

endmodule

// File: tb/nvm_wr_ctrl_tb_top.sv
`timescale 1ns/1ps
module nvm_wr_ctrl_tb_top;

    localparam int P     = 16;
    localparam int DEPTH = 64;

    localparam logic [7:0] B_START = 8'h01;
    localparam logic [7:0] B_WEN   = 8'h02;
    localparam logic [7:0] B_ERR   = 8'h04;
    localparam logic [7:0] B_ERASE = 8'h08;
    localparam logic [7:0] B_CFG   = 8'h40;
    localparam logic [7:0] B_MEM   = 8'h80;

    logic        clk = 1'b0;
    logic        rst, warm_rst, bus_wr;
    logic [2:0]  bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        irq, mem_stb, mem_erase;
    logic [1:0]  mem_target;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;

    int checks   = 0;
    int failures = 0;

    logic [23:0] rec_addr [128];
    logic [7:0]  rec_data [128];
    logic [1:0]  rec_tgt  [128];
    logic        rec_er   [128];
    int          rec_n = 0;

    always #2 clk = ~clk;

    nvm_wr_ctrl #(.PROG_CYCLES(P), .HOLD_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .warm_rst(warm_rst), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .mem_stb(mem_stb), .mem_target(mem_target),
        .mem_erase(mem_erase), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // behavioural array model: logs every strobe
    always @(negedge clk) begin
        if (!rst && mem_stb) begin
            if (rec_n < 128) begin
                rec_addr[rec_n] = mem_addr;
                rec_data[rec_n] = mem_wdata;
                rec_tgt[rec_n]  = mem_target;
                rec_er[rec_n]   = mem_erase;
            end
            rec_n = rec_n + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_ptr(input logic [23:0] p);
        wr(3'd3, p[7:0]); wr(3'd4, p[15:8]); wr(3'd5, p[23:16]);
    endtask

    task automatic arm_and_start(input logic [7:0] mode);
        wr(3'd0, mode | B_WEN);
        wr(3'd1, 8'h55);
        wr(3'd1, 8'hAA);
        wr(3'd0, mode | B_WEN | B_START);
    endtask

    task automatic count_busy(output int n);
        logic [7:0] v;
        n = 0;
        rd(3'd0, v);
        while (v[0] && n < 1000) begin
            n++;
            @(negedge clk);
            rd(3'd0, v);
        end
    endtask

    task automatic clear_flag_check(input string req);
        logic [7:0] v;
        rd(3'd7, v);
        check(req, {v[0], irq}, 2'b11);
        wr(3'd7, 8'h00);
        rd(3'd7, v);
        check(req, {v[0], irq}, 2'b00);
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0]  v;
        logic [23:0] ptr;
        int          n, n1;

        rst = 1'b1; warm_rst = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, v); check("R1 ctrl", v, 8'h00);
        rd(3'd7, v); check("R1 flag", {v, irq}, 9'h0);
        rd(3'd2, v); check("R12 latch reset", v, 8'h00);

        // R12 pointer and latch read back
        set_ptr(24'h56_34_12);
        rd(3'd3, v); check("R12 ptr lo", v, 8'h12);
        rd(3'd4, v); check("R12 ptr hi", v, 8'h34);
        rd(3'd5, v); check("R12 ptr up", v, 8'h56);
        wr(3'd2, 8'h9C);
        rd(3'd2, v); check("R12 latch", v, 8'h9C);

        // R2 unlock register reads zero
        wr(3'd1, 8'h5A);
        rd(3'd1, v); check("R2 unlock read", v, 8'h00);
        wr(3'd1, 8'h55);
        rd(3'd1, v); check("R2 unlock read after key", v, 8'h00);

        // R3 broken handshakes
        for (int c = 0; c < 6; c++) begin
            wr(3'd0, 8'h00);
            rec_n = 0;
            case (c)
                0: begin wr(3'd0, B_WEN); end
                1: begin wr(3'd0, B_WEN); wr(3'd1, 8'h55); end
                2: begin wr(3'd0, B_WEN); wr(3'd1, 8'h55); wr(3'd2, 8'h9C); wr(3'd1, 8'hAA); end
                3: begin wr(3'd0, B_WEN); wr(3'd1, 8'hAA); wr(3'd1, 8'h55); end
                4: begin wr(3'd1, 8'h55); wr(3'd1, 8'hAA); end
                default: begin wr(3'd0, B_WEN); wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd2, 8'h9C); end
            endcase
            wr(3'd0, B_WEN | B_START);
            repeat (3) @(negedge clk);
            rd(3'd0, v);
            check($sformatf("R3 reject case %0d start/err", c), {v[0], v[2]}, 2'b01);
            check($sformatf("R3 reject case %0d no strobe", c), rec_n, 0);
            wr(3'd0, 8'h00);
            rd(3'd0, v);
            check($sformatf("R11 err clear case %0d", c), v[2], 1'b0);
        end

        // R1 + R8: row write from a freshly reset buffer sends all 0xFF
        ptr = 24'h56_34_12;
        rec_n = 0;
        arm_and_start(B_MEM);
        count_busy(n);
        check("R4 row write duration", n, DEPTH + P);
        @(negedge clk); #1;
        check("R8 row strobe count", rec_n, DEPTH);
        n1 = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rec_data[i] !== 8'hFF || rec_addr[i] !== {ptr[23:6], 6'(i)} || rec_tgt[i] !== 2'b01
                || rec_er[i] !== 1'b0)
                n1++;
        end
        check("R1 reset buffer streamed as FF", n1, 0);
        clear_flag_check("R10 after row write");

        // R7 fill buffer with an arithmetic pattern
        for (int i = 0; i < DEPTH; i++) begin
            wr(3'd3, 8'h40 | 8'(i));
            wr(3'd2, 8'((i * 37 + 5) & 255));
            wr(3'd6, 8'h00);
        end
        ptr = 24'h56_34_7F;
        rec_n = 0;
        arm_and_start(B_MEM);
        // R4 software attempt to clear start is ignored
        wr(3'd0, B_MEM | B_WEN);
        rd(3'd0, v); check("R4 start survives clear write", v[0], 1'b1);
        // R7 table write during busy is ignored
        wr(3'd3, 8'h40); wr(3'd2, 8'h00); wr(3'd6, 8'h00);
        count_busy(n);
        @(negedge clk); #1;
        check("R8 pattern strobe count", rec_n, DEPTH);
        n1 = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rec_data[i] !== 8'((i * 37 + 5) & 255) || rec_addr[i] !== {ptr[23:6], 6'(i)})
                n1++;
        end
        check("R7 R8 pattern rows", n1, 0);
        clear_flag_check("R10 after pattern write");

        // R8 buffer refilled to FF after row write
        set_ptr(24'h56_34_7F);
        rec_n = 0;
        arm_and_start(B_MEM);
        count_busy(n);
        @(negedge clk); #1;
        n1 = 0;
        for (int i = 0; i < DEPTH; i++) if (rec_data[i] !== 8'hFF) n1++;
        check("R8 refill to FF", n1, 0);
        wr(3'd7, 8'hFF);
        rd(3'd7, v); check("R10 writing 1 keeps flag", v[0], 1'b1);
        clear_flag_check("R10 after refill write");

        // R5 R6 R9 sweep over all single-strobe modes
        for (int k = 0; k < 8; k++) begin
            logic cf, ms, er;
            logic [7:0] mode;
            cf = k[2]; ms = k[1]; er = k[0];
            if (!cf && ms && !er) continue;
            mode = (ms ? B_MEM : 8'h00) | (cf ? B_CFG : 8'h00) | (er ? B_ERASE : 8'h00);
            ptr = 24'h0A_00_05 + 24'(k) * 24'h00_11_13;
            set_ptr(ptr);
            wr(3'd2, 8'hC0 + 8'(k));
            rec_n = 0;
            arm_and_start(mode);
            count_busy(n);
            check($sformatf("R4 single duration k=%0d", k), n, 1 + P);
            @(negedge clk); #1;
            check($sformatf("R9 strobe count k=%0d", k), rec_n, 1);
            check($sformatf("R5 target k=%0d", k), rec_tgt[0], cf ? 2'b10 : (ms ? 2'b01 : 2'b00));
            check($sformatf("R6 erase flag k=%0d", k), rec_er[0], er);
            if (er) begin
                check($sformatf("R6 erase addr k=%0d", k), rec_addr[0], {ptr[23:6], 6'd0});
            end else begin
                check($sformatf("R9 addr k=%0d", k), rec_addr[0], ptr);
                check($sformatf("R9 data k=%0d", k), rec_data[0], 8'hC0 + 8'(k));
            end
            rd(3'd0, v); check($sformatf("R3 no err k=%0d", k), v[2], 1'b0);
            clear_flag_check($sformatf("R10 k=%0d", k));
        end

        // R11 warm reset in the middle of a row write
        set_ptr(24'h12_34_00);
        rec_n = 0;
        arm_and_start(B_MEM);
        repeat (10) @(negedge clk);
        warm_rst = 1'b1;
        @(negedge clk);
        warm_rst = 1'b0;
        #1;
        n1 = rec_n;
        repeat (20 + P) @(negedge clk);
        #1;
        check("R11 strobes frozen", rec_n, n1);
        check("R11 partial burst", (n1 > 0 && n1 < DEPTH), 1'b1);
        rd(3'd0, v); check("R11 start/err after abort", {v[0], v[2]}, 2'b01);
        rd(3'd7, v); check("R11 no completion flag", {v[0], irq}, 2'b00);
        wr(3'd0, 8'h00);
        rd(3'd0, v); check("R11 err cleared", v[2], 1'b0);

        // R3 accepted start after abort still works
        rec_n = 0;
        set_ptr(24'h00_00_21);
        arm_and_start(8'h00);
        count_busy(n);
        check("R3 accept after abort", n, 1 + P);
        clear_flag_check("R10 final");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule